// File: doc/BRIEF.md
# 8-bit PWM Timer/Counter

This block is an up/up-down counter with one compare channel that drives a single waveform output. It advances only on cycles where the `tick` input is high, so a prescaler or an external event divider outside the block sets the count rate. Software programs it through a small write port with four addresses: a control word holding the mode and the output action, a direct counter load, the compare value and the interrupt enables.

There are four counting modes. In free-running mode the counter wraps at all-ones. In clear-on-compare mode it returns to zero after it reaches the compare value. In fast PWM it runs as a single-slope sawtooth. In phase-correct PWM it counts up and then down as a triangle. The compare value is double-buffered in both PWM modes, so a duty-cycle change takes effect only at the start of a period. The compare and overflow events each set a sticky flag. A write-one strobe or an interrupt acknowledge clears each flag, and each flag raises a masked interrupt request.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count, both flags, the waveform output, its output enable and both interrupt requests are 0, and the mode is free-running.
- R2: Write addresses: 0 is control (bits [1:0] mode: 0 free-running, 1 phase-correct PWM, 2 clear-on-compare, 3 fast PWM; bits [3:2] output action code), 1 loads the counter, 2 is the compare value, 3 is the interrupt enables (bit 0 compare, bit 1 overflow). The count changes only on a `tick` or on a counter load.
- R3: In free-running mode each tick adds one and the count wraps from 0xFF to 0. The tick taken at 0xFF sets the overflow flag.
- R4: In clear-on-compare mode the tick taken while the count equals the compare value sets the compare flag and returns the count to 0. The overflow flag sets only on a tick taken at 0xFF.
- R5: Fast PWM counts 0 to 0xFF and sets the overflow flag on the tick at 0xFF. Action code 2 clears the output on a match and sets it on the tick at 0xFF. Code 3 does the reverse. Code 1 drops the output enable.
- R6: Phase-correct PWM counts 0 up to 0xFF and back down to 0. Each endpoint lasts one tick. The overflow flag sets on the tick that leaves 0 while counting down. Code 2 clears the output on a match after which the count rises and sets it on a match after which the count falls. Code 3 does the reverse.
- R7: A compare write takes effect at once in the non-PWM modes. In the PWM modes it is held in a buffer and loaded on the tick taken at 0xFF; that tick still compares against the old value.
- R8: In a PWM mode with compare value 0xFF and action code 2 or 3, the match does not drive the output (the compare flag still sets). The output is set for code 2, or cleared for code 3, on the tick at 0xFF.
- R9: In the non-PWM modes a match toggles the output for code 1, clears it for code 2 and sets it for code 3. Code 0 drops the output enable.
- R10: The force strobe applies the action of R9 in the non-PWM modes without setting the compare flag or changing the count. It has no effect in the PWM modes.
- R11: A counter load suppresses any compare match on the next tick.
- R12: A flag is cleared by its write-one strobe or by its acknowledge. If a flag sets and is cleared in the same cycle, the set wins.
- R13: Each interrupt request is high exactly when its flag, its enable bit and `glob_ie` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| force_cmp | input | 1 | Force-compare strobe |
| clr_cmp | input | 1 | Write-one clear of the compare flag |
| clr_ovf | input | 1 | Write-one clear of the overflow flag |
| ack_cmp | input | 1 | Interrupt acknowledge, compare vector |
| ack_ovf | input | 1 | Interrupt acknowledge, overflow vector |
| glob_ie | input | 1 | Global interrupt enable |
| count | output | 8 | Current counter value |
| wave_out | output | 1 | Waveform output value |
| wave_oe | output | 1 | Waveform output enable |
| cmp_flag | output | 1 | Compare match flag |
| ovf_flag | output | 1 | Overflow flag |
| irq_cmp | output | 1 | Masked compare interrupt request |
| irq_ovf | output | 1 | Masked overflow interrupt request |

## Verification
A flag-setting event can fall in the same cycle as a software clear of that flag. The bench provokes this by raising `tick` with the counter at 0xFF in the same cycle as the overflow clear strobe, and it expects the flag to be high afterwards. A counter load can also coincide with a compare match on the following tick. This case is provoked by loading the compare value itself into the counter, and it is judged by a flag that stays clear and an output that keeps its value. A third coincidence is the compare value sitting at TOP in a PWM mode, where match and TOP fall on the same tick. Only the TOP action must reach the output across a full period.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;

   typedef enum logic [1:0] {
      TM_FREE  = 2'd0,
      TM_PHASE = 2'd1,
      TM_CTC   = 2'd2,
      TM_FAST  = 2'd3
   } tmr_mode_e;

   localparam logic [1:0] A_CTRL  = 2'd0;
   localparam logic [1:0] A_COUNT = 2'd1;
   localparam logic [1:0] A_CMP   = 2'd2;
   localparam logic [1:0] A_IEN   = 2'd3;

   localparam int NFLAG = 2;
   localparam int F_CMP = 0;
   localparam int F_OVF = 1;

   // bit 0 of the mode code marks the two PWM modes
   function automatic logic is_pwm(tmr_mode_e m);
      return m[0];
   endfunction

endpackage

// File: rtl/pwm_timer8_counter.sv
module pwm_timer8_counter
   import pwm_timer8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  tmr_mode_e    mode,
   input  logic [W-1:0] cmp_val,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         match_evt,
   output logic         ovf_evt,
   output logic         top_evt,
   output logic         match_up
);

   localparam logic [W-1:0] MAXV = {W{1'b1}};
   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = W'(1);

   logic         blk_q;
   logic         dir_q;
   logic         dir_d;
   logic [W-1:0] cnt_d;
   logic         step;
   logic         at_cmp;
   logic         at_max;
   logic         at_zero;

   assign step    = tick & ~load;
   assign at_cmp  = (cnt == cmp_val);
   assign at_max  = (cnt == MAXV);
   assign at_zero = (cnt == ZERO);

   assign match_evt = step & at_cmp & ~blk_q;
   assign top_evt   = step & at_max;
   assign ovf_evt   = step & ((mode == TM_PHASE) ? (dir_q & at_zero) : at_max);
   // direction the count takes after this tick
   assign match_up  = at_zero | (~dir_q & ~at_max);

   always_comb begin
      cnt_d = cnt;
      dir_d = dir_q;
      if (load) begin
         cnt_d = load_val;
      end else if (tick) begin
         case (mode)
            TM_CTC:   cnt_d = (at_cmp && !blk_q) ? ZERO : cnt + ONE;
            TM_PHASE: begin
               if (!dir_q) begin
                  if (at_max) begin
                     cnt_d = MAXV - ONE;
                     dir_d = 1'b1;
                  end else begin
                     cnt_d = cnt + ONE;
                  end
               end else begin
                  if (at_zero) begin
                     cnt_d = ONE;
                     dir_d = 1'b0;
                  end else begin
                     cnt_d = cnt - ONE;
                  end
               end
            end
            default:  cnt_d = cnt + ONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         dir_q <= 1'b0;
         blk_q <= 1'b0;
      end else begin
         cnt   <= cnt_d;
         dir_q <= dir_d;
         if (load)
            blk_q <= 1'b1;
         else if (tick)
            blk_q <= 1'b0;
      end
   end

endmodule

// File: rtl/pwm_timer8_cmpreg.sv
module pwm_timer8_cmpreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         pwm,
   input  logic         top_evt,
   output logic [W-1:0] active
);

   logic [W-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         active   <= '0;
      end else begin
         if (wr)
            shadow_q <= wdata;
         if (wr && !pwm)
            active <= wdata;
         else if (pwm && top_evt)
            active <= wr ? wdata : shadow_q;
      end
   end

endmodule

// File: rtl/pwm_timer8_wave.sv
module pwm_timer8_wave
   import pwm_timer8_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  tmr_mode_e mode,
   input  logic [1:0] act,
   input  logic      match_evt,
   input  logic      match_up,
   input  logic      top_evt,
   input  logic      cmp_is_top,
   input  logic      force_cmp,
   output logic      wave,
   output logic      wave_oe
);

   logic nxt;
   logic pwm;

   assign pwm     = is_pwm(mode);
   assign wave_oe = (act != 2'b00) && !(pwm && act == 2'b01);

   always_comb begin
      nxt = wave;
      if (!pwm) begin
         if (match_evt || force_cmp) begin
            case (act)
               2'b01:   nxt = ~wave;
               2'b10:   nxt = 1'b0;
               2'b11:   nxt = 1'b1;
               default: nxt = wave;
            endcase
         end
      end else if (act[1]) begin
         if (mode == TM_FAST) begin
            if (top_evt)
               nxt = ~act[0];
            else if (match_evt && !cmp_is_top)
               nxt = act[0];
         end else begin
            if (top_evt && cmp_is_top)
               nxt = ~act[0];
            else if (match_evt && !cmp_is_top)
               nxt = match_up ? act[0] : ~act[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wave <= 1'b0;
      else
         wave <= nxt;
   end

endmodule

// File: rtl/pwm_timer8_flag.sv
module pwm_timer8_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (set_i)
         q <= 1'b1;
      else if (clr_i)
         q <= 1'b0;
   end

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
   import pwm_timer8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic         force_cmp,
   input  logic         clr_cmp,
   input  logic         clr_ovf,
   input  logic         ack_cmp,
   input  logic         ack_ovf,
   input  logic         glob_ie,
   output logic [W-1:0] count,
   output logic         wave_out,
   output logic         wave_oe,
   output logic         cmp_flag,
   output logic         ovf_flag,
   output logic         irq_cmp,
   output logic         irq_ovf
);

   localparam logic [W-1:0] MAXV = {W{1'b1}};

   generate
      if (W < 4) begin : g_bad_width
         $error("pwm_timer8: W must be at least 4 to hold the control fields");
      end
   endgenerate

   tmr_mode_e        mode_q;
   logic [1:0]       com_q;
   logic [NFLAG-1:0] ien_q;
   logic [W-1:0]     cmp_act;
   logic             match_evt;
   logic             ovf_evt;
   logic             top_evt;
   logic             match_up;
   logic             wr_count;
   logic             wr_cmpv;
   logic [NFLAG-1:0] fset;
   logic [NFLAG-1:0] fclr;
   logic [NFLAG-1:0] fq;

   assign wr_count = wr_en && (wr_addr == A_COUNT);
   assign wr_cmpv  = wr_en && (wr_addr == A_CMP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= TM_FREE;
         com_q  <= 2'b00;
         ien_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) begin
            mode_q <= tmr_mode_e'(wr_data[1:0]);
            com_q  <= wr_data[3:2];
         end
         if (wr_addr == A_IEN)
            ien_q <= wr_data[NFLAG-1:0];
      end
   end

   pwm_timer8_counter #(.W(W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .mode      (mode_q),
      .cmp_val   (cmp_act),
      .load      (wr_count),
      .load_val  (wr_data),
      .cnt       (count),
      .match_evt (match_evt),
      .ovf_evt   (ovf_evt),
      .top_evt   (top_evt),
      .match_up  (match_up)
   );

   pwm_timer8_cmpreg #(.W(W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_cmpv),
      .wdata   (wr_data),
      .pwm     (is_pwm(mode_q)),
      .top_evt (top_evt),
      .active  (cmp_act)
   );

   pwm_timer8_wave u_wave (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode_q),
      .act        (com_q),
      .match_evt  (match_evt),
      .match_up   (match_up),
      .top_evt    (top_evt),
      .cmp_is_top (cmp_act == MAXV),
      .force_cmp  (force_cmp),
      .wave       (wave_out),
      .wave_oe    (wave_oe)
   );

   assign fset[F_CMP] = match_evt;
   assign fset[F_OVF] = ovf_evt;
   assign fclr[F_CMP] = clr_cmp | ack_cmp;
   assign fclr[F_OVF] = clr_ovf | ack_ovf;

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         pwm_timer8_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (fset[i]),
            .clr_i (fclr[i]),
            .q     (fq[i])
         );
      end
   endgenerate

   assign cmp_flag = fq[F_CMP];
   assign ovf_flag = fq[F_OVF];
   assign irq_cmp  = fq[F_CMP] & ien_q[F_CMP] & glob_ie;
   assign irq_ovf  = fq[F_OVF] & ien_q[F_OVF] & glob_ie;

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk
   import pwm_timer8_pkg::*;
#(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         wr_en,
   input logic [1:0]   wr_addr,
   input logic         force_cmp,
   input logic         clr_cmp,
   input logic         ack_cmp,
   input logic         glob_ie,
   input logic [W-1:0] count,
   input logic         cmp_flag,
   input logic         ovf_flag,
   input logic         irq_cmp,
   input logic         irq_ovf,
   input logic         match_evt,
   input tmr_mode_e    mode_q
);

   logic ld;
   assign ld = wr_en && (wr_addr == A_COUNT);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld) |=> $stable(count));

   // R3
   ovf_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && mode_q != TM_PHASE && count == {W{1'b1}}) |=> ovf_flag);

   // R4
   ctc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && mode_q == TM_CTC && !ld) |=> (count == '0));

   // R6
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && mode_q == TM_PHASE) |=>
         ((count == W'($past(count) + 1'b1)) || (count == W'($past(count) - 1'b1))));

   // R10
   force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_cmp && !match_evt && !cmp_flag) |=> !cmp_flag);

   // R12
   cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_cmp || ack_cmp) && !match_evt) |=> !cmp_flag);

   // R13
   irq_cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_cmp |-> (cmp_flag && glob_ie));

   // R13
   irq_ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf |-> (ovf_flag && glob_ie));

endmodule

bind pwm_timer8 pwm_timer8_chk #(.W(W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .force_cmp (force_cmp),
   .clr_cmp   (clr_cmp),
   .ack_cmp   (ack_cmp),
   .glob_ie   (glob_ie),
   .count     (count),
   .cmp_flag  (cmp_flag),
   .ovf_flag  (ovf_flag),
   .irq_cmp   (irq_cmp),
   .irq_ovf   (irq_ovf),
   .match_evt (match_evt),
   .mode_q    (mode_q)
);

// File: tb/pwm_timer8_tb_top.sv
`timescale 1ns/1ps
module pwm_timer8_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       force_cmp = 1'b0;
   logic       clr_cmp = 1'b0;
   logic       clr_ovf = 1'b0;
   logic       ack_cmp = 1'b0;
   logic       ack_ovf = 1'b0;
   logic       glob_ie = 1'b0;
   logic [7:0] count;
   logic       wave_out, wave_oe, cmp_flag, ovf_flag, irq_cmp, irq_ovf;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   pwm_timer8 #(.W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .force_cmp(force_cmp), .clr_cmp(clr_cmp), .clr_ovf(clr_ovf),
      .ack_cmp(ack_cmp), .ack_ovf(ack_ovf), .glob_ie(glob_ie), .count(count),
      .wave_out(wave_out), .wave_oe(wave_oe), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
      .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
   );

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         cyc();
      end
      tick = 1'b0;
   endtask

   task automatic clr_flags();
      clr_cmp = 1'b1; clr_ovf = 1'b1;
      cyc();
      clr_cmp = 1'b0; clr_ovf = 1'b0;
   endtask

   task automatic pulse_force();
      force_cmp = 1'b1;
      cyc();
      force_cmp = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 count", count, 0);
      chk("R1 flags", {cmp_flag, ovf_flag}, 0);
      chk("R1 wave", {wave_out, wave_oe}, 0);
      chk("R1 irq", {irq_cmp, irq_ovf}, 0);
   endtask

   task automatic t_free();
      wr(2'd0, 8'h00);
      tk(5);
      chk("R3 count after 5 ticks", count, 5);
      cyc(); cyc(); cyc();
      chk("R2 count holds without tick", count, 5);
      wr(2'd1, 8'hFE);
      chk("R2 counter load", count, 8'hFE);
      tk(1);
      chk("R3 count FF", count, 8'hFF);
      chk("R3 no overflow before wrap", ovf_flag, 0);
      tk(1);
      chk("R3 wrap to 0", count, 0);
      chk("R3 overflow on wrap", ovf_flag, 1);
      clr_ovf = 1'b1; cyc(); clr_ovf = 1'b0;
      chk("R12 write-one clear", ovf_flag, 0);
   endtask

   task automatic t_ctc();
      wr(2'd2, 8'd3);
      wr(2'd0, 8'h06);           // CTC, toggle
      wr(2'd1, 8'd0);
      clr_flags();
      tk(3);
      chk("R4 count reaches compare", count, 3);
      chk("R4 no flag before match", cmp_flag, 0);
      tk(1);
      chk("R4 count cleared", count, 0);
      chk("R4 compare flag", cmp_flag, 1);
      chk("R9 toggle on match", wave_out, 1);
      chk("R9 enable on", wave_oe, 1);
      tk(4);
      chk("R9 toggle again", wave_out, 0);
      chk("R4 no overflow", ovf_flag, 0);
      wr(2'd0, 8'h0E);           // CTC, set
      tk(4);
      chk("R9 set on match", wave_out, 1);
      wr(2'd0, 8'h0A);           // CTC, clear
      tk(4);
      chk("R9 clear on match", wave_out, 0);
      wr(2'd0, 8'h02);           // CTC, disconnected
      chk("R9 code 0 disables", wave_oe, 0);
   endtask

   task automatic t_force();
      wr(2'd0, 8'h0E);           // CTC, set
      wr(2'd1, 8'd1);
      clr_flags();
      pulse_force();
      chk("R10 force sets output", wave_out, 1);
      chk("R10 force keeps count", count, 1);
      chk("R10 force sets no flag", cmp_flag, 0);
      wr(2'd0, 8'h0B);           // fast PWM, clear-on-match
      pulse_force();
      chk("R10 force ignored in PWM", wave_out, 1);
   endtask

   task automatic t_block();
      logic w0;
      wr(2'd0, 8'h04);           // free-running, toggle
      wr(2'd2, 8'd5);
      wr(2'd1, 8'd5);
      clr_flags();
      w0 = wave_out;
      tk(1);
      chk("R11 count advances", count, 6);
      chk("R11 match blocked flag", cmp_flag, 0);
      chk("R11 match blocked output", wave_out, w0);
      wr(2'd1, 8'd4);
      tk(2);
      chk("R11 later match flag", cmp_flag, 1);
      chk("R11 later match output", wave_out, !w0);
   endtask

   task automatic t_fast();
      int errs;
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h10);           // immediate in free-running
      wr(2'd0, 8'h0B);           // fast, code 2
      wr(2'd2, 8'h20);           // buffered
      clr_flags();
      wr(2'd1, 8'h0E);
      tk(3);
      chk("R7 old compare still active", cmp_flag, 1);
      chk("R5 clear on match", wave_out, 0);
      wr(2'd1, 8'hFE);
      tk(2);
      chk("R5 wrap", count, 0);
      chk("R5 set at top", wave_out, 1);
      chk("R5 overflow at top", ovf_flag, 1);
      wr(2'd1, 8'h1E);
      tk(2);
      chk("R7 no match before new value", wave_out, 1);
      tk(1);
      chk("R7 buffered value applied", wave_out, 0);
      wr(2'd0, 8'h0F);           // fast, code 3
      wr(2'd1, 8'h1F);
      tk(2);
      chk("R5 inverted set on match", wave_out, 1);
      wr(2'd1, 8'hFF);
      tk(1);
      chk("R5 inverted clear at top", wave_out, 0);
      wr(2'd0, 8'h07);           // fast, code 1
      chk("R5 reserved code disables", wave_oe, 0);
      wr(2'd0, 8'h0B);
      wr(2'd2, 8'hFF);
      wr(2'd1, 8'hFF);
      tk(1);
      chk("R8 set at top", wave_out, 1);
      clr_flags();
      errs = 0;
      for (int i = 0; i < 256; i++) begin
         tick = 1'b1;
         cyc();
         if (wave_out !== 1'b1) errs++;
      end
      tick = 1'b0;
      chk("R8 match at top ignored", errs, 0);
      chk("R8 flag still sets", cmp_flag, 1);
   endtask

   task automatic t_phase();
      wr(2'd0, 8'h0A);           // CTC, clear
      pulse_force();
      chk("R10 force clears", wave_out, 0);
      wr(2'd0, 8'h09);           // phase, code 2
      wr(2'd2, 8'h80);           // buffered, active stays FF
      clr_flags();
      wr(2'd1, 8'hFE);
      tk(2);
      chk("R6 turn at top", count, 8'hFE);
      chk("R8 phase top sets", wave_out, 1);
      chk("R6 no overflow at top", ovf_flag, 0);
      wr(2'd0, 8'h0D);           // phase, code 3
      tk(126);
      chk("R6 down to compare", count, 8'h80);
      chk("R6 before down match", wave_out, 1);
      tk(1);
      chk("R6 clear on down match", wave_out, 0);
      tk(127);
      chk("R6 bottom reached", count, 0);
      chk("R6 no overflow yet", ovf_flag, 0);
      tk(1);
      chk("R6 turn at bottom", count, 1);
      chk("R6 overflow at bottom", ovf_flag, 1);
      tk(127);
      chk("R6 up to compare", wave_out, 0);
      tk(1);
      chk("R6 set on up match", wave_out, 1);
      tk(126);
      chk("R6 reaches top", count, 8'hFF);
      tk(1);
      chk("R6 top lasts one tick", count, 8'hFE);
   endtask

   task automatic t_flags();
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h05);
      wr(2'd1, 8'hFF);
      clr_flags();
      tick = 1'b1; clr_ovf = 1'b1;
      cyc();
      tick = 1'b0; clr_ovf = 1'b0;
      chk("R12 set wins over clear", ovf_flag, 1);
      ack_ovf = 1'b1; cyc(); ack_ovf = 1'b0;
      chk("R12 acknowledge clears", ovf_flag, 0);
      wr(2'd3, 8'h02);
      glob_ie = 1'b1;
      wr(2'd1, 8'hFF);
      tk(1);
      chk("R13 overflow request", irq_ovf, 1);
      chk("R13 compare request masked", irq_cmp, 0);
      glob_ie = 1'b0;
      cyc();
      chk("R13 global disable", irq_ovf, 0);
      wr(2'd3, 8'h01);
      glob_ie = 1'b1;
      wr(2'd1, 8'd4);
      tk(2);
      chk("R13 compare request", irq_cmp, 1);
      chk("R13 overflow masked", irq_ovf, 0);
      ack_cmp = 1'b1; cyc(); ack_cmp = 1'b0;
      chk("R12 compare acknowledge", cmp_flag, 0);
      chk("R13 request drops", irq_cmp, 0);
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_free();
      t_ctc();
      t_force();
      t_block();
      t_fast();
      t_phase();
      t_flags();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule